// File: doc/BRIEF.md
# Multi-channel tamper input detector

This block watches a set of tamper input pins from a slow, always-on clock domain. Each channel can be enabled on its own, has its own match polarity, and picks one of two stability windows: a short one or a long debounce. A channel records a tamper event only after its synchronized input has stayed at the programmed level for the full window without a break. An event sets a sticky per-channel status bit, and any set status bit drives a combined event output.

Software reaches the block through a simple write port and a read port with three addresses: a control register holding one byte per channel, a lock register that must hold a fixed key before control writes are accepted, and a status register cleared by writing ones. Every accepted write starts a short busy window, shown on `wr_ready`, and writes issued during that window are discarded. The pull-up enable bits of the control register are driven straight out to the pad logic.

Top module: `tamper_watch`

## Requirements
- R1: After reset the control register, status register and lock state are all zero (lock register bit 0 = 0 means locked), `tamper_evt` and `pullup_en` are low and `wr_ready` is high.
- R2: Address 0 is the control register. Byte i drives channel i: bit 0 enable, bit 1 match level, bit 2 pull-up, bit 3 long-filter select. The upper four bits of every byte read as zero whatever is written.
- R3: Address 1 is the lock register. Writing `UNLOCK_KEY` sets its bit 0 to 1 (unlocked). Writing any other value clears it. A control write made while it is locked leaves the control register unchanged.
- R4: An accepted write drops `wr_ready` for exactly `WR_GAP` cycles. A write presented while `wr_ready` is low has no effect on any register.
- R5: A channel with its enable bit at 0 never sets its status bit, whatever its input does.
- R6: With level bit 0 a channel matches a low input. With level bit 1 it matches a high input. The opposite input level never raises an event.
- R7: With filter select 0, a matching input that is held steady sets the status bit at the (`SHORT_CNT`+2)-th rising edge after the pin changes. Two of those edges are spent in the synchronizer.
- R8: With filter select 1, the same happens at the (`LONG_CNT`+2)-th rising edge.
- R9: Any break in the match restarts qualification. A run of L matching cycles sets status only if L is at least the selected window.
- R10: Status bits are sticky, and `tamper_evt` is high whenever any status bit is set.
- R11: Address 2 is the status register, with bit i for channel i. Writing 1 to a bit clears it only when that channel's synchronized input no longer matches, or when the channel is disabled. Otherwise the bit stays set.
- R12: Clearing a channel's enable bit discards its progress. After it is re-enabled, a full window is needed again.
- R13: `pullup_en[i]` follows control bit 2 of byte i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tamper_pin | input | NUM_CH | Raw tamper inputs |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 lock, 2 status) |
| wr_data | input | 8*NUM_CH | Write data |
| wr_ready | output | 1 | High when a write will be accepted |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8*NUM_CH | Read data for rd_addr |
| pullup_en | output | NUM_CH | Pull-up enables for the pads |
| tamper_evt | output | 1 | OR of all status bits |

## Verification
The bench builds the block with `SHORT_CNT`=2, `LONG_CNT`=24 and `WR_GAP`=3, and keeps four channels and the default key. The shortened long window keeps the edge-exact timing of both filters, the restart after a one-cycle break, and the re-enable case cheap to reach. Random pulse lengths that straddle both windows then probe the accept/reject boundary on every channel and for both polarities. A gap of three cycles leaves a clear window in which to issue a write that must be discarded.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
    localparam int CH_BITS = 8;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_LOCK = 2'd1,
        ADDR_STAT = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    // low nibble of one channel byte; en is bit 0
    typedef struct packed {
        logic filt;
        logic pu;
        logic lev;
        logic en;
    } chan_cfg_t;
endpackage

// File: rtl/tamper_sync.sv
module tamper_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/tamper_qual.sv
module tamper_qual
    import tamper_pkg::*;
#(
    parameter int SHORT_CNT = 2,
    parameter int LONG_CNT  = 3071
) (
    input  logic      clk,
    input  logic      rst_n,
    input  chan_cfg_t cfg,
    input  logic      pin_s,
    output logic      match,
    output logic      hit
);
    localparam int CW = $clog2(LONG_CNT + 1);
    localparam logic [CW-1:0] LIM_S = CW'(SHORT_CNT - 1);
    localparam logic [CW-1:0] LIM_L = CW'(LONG_CNT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } qual_t;

    qual_t st_d, st_q;
    logic [CW-1:0] limit;

    always_comb begin
        st_d  = st_q;
        match = (pin_s == cfg.lev);
        limit = cfg.filt ? LIM_L : LIM_S;
        hit   = cfg.en && match && (st_q.cnt >= limit);
        if (!cfg.en || !match)      st_d.cnt = '0;
        else if (st_q.cnt < limit)  st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tamper_watch.sv
module tamper_watch
    import tamper_pkg::*;
#(
    parameter int          NUM_CH     = 4,
    parameter int          SHORT_CNT  = 2,
    parameter int          LONG_CNT   = 3071,
    parameter int          WR_GAP     = 2,
    parameter logic [31:0] UNLOCK_KEY = 32'h1ACC_E55D
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH-1:0]         tamper_pin,
    input  logic                      wr_en,
    input  logic [1:0]                wr_addr,
    input  logic [NUM_CH*CH_BITS-1:0] wr_data,
    output logic                      wr_ready,
    input  logic [1:0]                rd_addr,
    output logic [NUM_CH*CH_BITS-1:0] rd_data,
    output logic [NUM_CH-1:0]         pullup_en,
    output logic                      tamper_evt
);
    localparam int DW = NUM_CH * CH_BITS;
    localparam int GW = $clog2(WR_GAP + 1);
    localparam logic [DW-1:0] WMASK = {NUM_CH{8'h0F}};
    localparam logic [DW-1:0] KEY   = DW'(UNLOCK_KEY);

    typedef struct packed {
        logic [DW-1:0]     ctrl;
        logic              unlocked;
        logic [NUM_CH-1:0] status;
        logic [GW-1:0]     busy;
    } regs_t;

    regs_t st_d, st_q;

    logic [NUM_CH-1:0] pin_s;
    logic [NUM_CH-1:0] match;
    logic [NUM_CH-1:0] hit;
    logic [NUM_CH-1:0] clr_ok;
    logic              wr_ok;
    chan_cfg_t         cfg [NUM_CH];

    tamper_sync #(.W(NUM_CH)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (tamper_pin),
        .dout (pin_s)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign cfg[i]       = chan_cfg_t'(st_q.ctrl[i*CH_BITS +: 4]);
        assign pullup_en[i] = cfg[i].pu;
        assign clr_ok[i]    = !(cfg[i].en && match[i]);

        tamper_qual #(
            .SHORT_CNT(SHORT_CNT),
            .LONG_CNT (LONG_CNT)
        ) u_qual (
            .clk  (clk),
            .rst_n(rst_n),
            .cfg  (cfg[i]),
            .pin_s(pin_s[i]),
            .match(match[i]),
            .hit  (hit[i])
        );
    end

    always_comb begin
        st_d  = st_q;
        wr_ok = wr_en && (st_q.busy == '0);
        if (st_q.busy != '0) st_d.busy = st_q.busy - 1'b1;
        if (wr_ok) begin
            st_d.busy = GW'(WR_GAP);
            case (reg_addr_e'(wr_addr))
                ADDR_CTRL: if (st_q.unlocked) st_d.ctrl = wr_data & WMASK;
                ADDR_LOCK: st_d.unlocked = (wr_data == KEY);
                ADDR_STAT: st_d.status = st_q.status & ~(wr_data[NUM_CH-1:0] & clr_ok);
                default: ;
            endcase
        end
        st_d.status = st_d.status | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (reg_addr_e'(rd_addr))
            ADDR_CTRL: rd_data = st_q.ctrl;
            ADDR_LOCK: rd_data = DW'(st_q.unlocked);
            ADDR_STAT: rd_data = DW'(st_q.status);
            default:   rd_data = '0;
        endcase
    end

    assign wr_ready   = (st_q.busy == '0);
    assign tamper_evt = |st_q.status;

    logic [DW-1:0]     ctrl_q;
    logic              unlocked_q;
    logic [NUM_CH-1:0] status_q;
    assign ctrl_q     = st_q.ctrl;
    assign unlocked_q = st_q.unlocked;
    assign status_q   = st_q.status;
endmodule

// File: rtl/tamper_watch_chk.sv
module tamper_watch_chk
    import tamper_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DW     = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_ready,
    input logic [1:0]        wr_addr,
    input logic [DW-1:0]     wr_data,
    input logic [DW-1:0]     ctrl,
    input logic              unlocked,
    input logic [NUM_CH-1:0] status
);
    localparam logic [DW-1:0] RESV = {NUM_CH{8'hF0}};

    assert_resv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl & RESV) == '0);

    assert_locked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(ctrl));

    assert_busy_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ready) |=> !wr_ready);

    assert_busy_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ready |=> ($stable(ctrl) && $stable(unlocked)));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status[i]) |-> $past(ctrl[i*8]));

        assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(status[i]) |-> $past(wr_en && wr_ready &&
                                       wr_addr == ADDR_STAT && wr_data[i]));
    end
endmodule

bind tamper_watch tamper_watch_chk #(
    .NUM_CH(NUM_CH),
    .DW    (DW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_ready(wr_ready),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ctrl    (ctrl_q),
    .unlocked(unlocked_q),
    .status  (status_q)
);

// File: tb/sim_tamper_watch.sv
module sim_tamper_watch;
    localparam int          NCH   = 4;
    localparam int          SHORT = 2;
    localparam int          LONG  = 24;
    localparam int          GAP   = 3;
    localparam logic [31:0] KEY   = 32'h1ACC_E55D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  tamper_pin = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        wr_ready;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [3:0]  pullup_en;
    logic        tamper_evt;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    tamper_watch #(
        .NUM_CH(NCH), .SHORT_CNT(SHORT), .LONG_CNT(LONG),
        .WR_GAP(GAP), .UNLOCK_KEY(KEY)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .tamper_pin(tamper_pin),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_addr(rd_addr), .rd_data(rd_data), .pullup_en(pullup_en),
        .tamper_evt(tamper_evt)
    );

    function automatic logic [7:0] cbyte(bit en, bit lev, bit pu, bit filt);
        return {4'h0, filt, pu, lev, en};
    endfunction

    function automatic int window(bit filt);
        return filt ? LONG : SHORT;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h want %h", req, act, exp);
        end
    endtask

    task automatic tick(int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        while (!wr_ready) tick();
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [1:0] a, logic [31:0] exp);
        rd_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout want completion");
        summary();
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        rd_chk("R1 ctrl", 2'd0, 32'h0);
        rd_chk("R1 lock", 2'd1, 32'h0);
        rd_chk("R1 status", 2'd2, 32'h0);
        check("R1 evt/pullup/ready", {tamper_evt, pullup_en, wr_ready}, {1'b0, 4'h0, 1'b1});

        // R3 locked writes dropped
        wr(2'd0, 32'h0F0F0F0F);
        rd_chk("R3 locked ctrl", 2'd0, 32'h0);
        wr(2'd1, KEY);
        rd_chk("R3 unlocked", 2'd1, 32'h1);
        // R2 reserved nibbles read zero; R13 pull-ups mirror bit 2
        wr(2'd0, 32'hFFFFFFFF);
        rd_chk("R2 mask", 2'd0, 32'h0F0F0F0F);
        check("R13 pullup", {28'h0, pullup_en}, 32'hF);
        wr(2'd1, KEY ^ 32'h1);
        rd_chk("R3 relock", 2'd1, 32'h0);
        wr(2'd0, 32'h0);
        rd_chk("R3 relocked ctrl", 2'd0, 32'h0F0F0F0F);
        wr(2'd1, KEY);
        wr(2'd0, 32'h00000400);
        check("R13 pullup ch1", {28'h0, pullup_en}, 32'h2);

        // R4 busy window
        wr(2'd0, 32'h00000004);
        check("R4 ready low", {31'h0, wr_ready}, 32'h0);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'h00000400;
        tick();
        wr_en = 1'b0;
        rd_chk("R4 ignored write", 2'd0, 32'h00000004);
        tick(GAP - 2);
        check("R4 still busy", {31'h0, wr_ready}, 32'h0);
        tick();
        check("R4 ready again", {31'h0, wr_ready}, 32'h1);

        // R7 short filter timing, channel 0 high level
        wr(2'd0, {24'h0, cbyte(1, 1, 0, 0)});
        tick(GAP);
        tamper_pin[0] = 1'b1;
        tick(SHORT + 1);
        rd_chk("R7 before window", 2'd2, 32'h0);
        tick();
        rd_chk("R7 at window", 2'd2, 32'h1);
        check("R10 evt", {31'h0, tamper_evt}, 32'h1);
        // R11 clear refused while matching
        wr(2'd2, 32'h1);
        tick(GAP);
        rd_chk("R11 refused", 2'd2, 32'h1);
        tamper_pin[0] = 1'b0;
        tick(3);
        rd_chk("R10 sticky", 2'd2, 32'h1);
        wr(2'd2, 32'h1);
        rd_chk("R11 cleared", 2'd2, 32'h0);
        check("R10 evt low", {31'h0, tamper_evt}, 32'h0);

        // R6 low polarity on channel 1
        tamper_pin[1] = 1'b1;
        wr(2'd0, {16'h0, cbyte(1, 0, 0, 0), 8'h0});
        tick(GAP + 6);
        rd_chk("R6 high ignored", 2'd2, 32'h0);
        tamper_pin[1] = 1'b0;
        tick(SHORT + 2);
        rd_chk("R6 low match", 2'd2, 32'h2);
        tamper_pin[1] = 1'b1;
        tick(3);
        wr(2'd2, 32'h2);
        rd_chk("R11 ch1 cleared", 2'd2, 32'h0);

        // R8 long filter timing, channel 2
        wr(2'd0, {8'h0, cbyte(1, 1, 0, 1), 16'h0});
        tick(GAP);
        tamper_pin[2] = 1'b1;
        tick(LONG + 1);
        rd_chk("R8 before window", 2'd2, 32'h0);
        tick();
        rd_chk("R8 at window", 2'd2, 32'h4);
        tamper_pin[2] = 1'b0;
        tick(3);
        wr(2'd2, 32'h4);

        // R9 one-cycle break restarts
        tick(GAP);
        tamper_pin[2] = 1'b1;
        tick(20);
        tamper_pin[2] = 1'b0;
        tick();
        tamper_pin[2] = 1'b1;
        tick(20);
        rd_chk("R9 broken run", 2'd2, 32'h0);

        // R5 disabled channel stays quiet; R12 re-enable restarts
        wr(2'd0, {8'h0, cbyte(0, 1, 0, 1), 16'h0});
        tick(40);
        rd_chk("R5 disabled", 2'd2, 32'h0);
        wr(2'd0, {8'h0, cbyte(1, 1, 0, 1), 16'h0});
        tick(LONG - 1);
        rd_chk("R12 restart pending", 2'd2, 32'h0);
        tick();
        rd_chk("R12 restart done", 2'd2, 32'h4);
        tamper_pin[2] = 1'b0;
        tick(3);
        wr(2'd2, 32'hF);

        // R9 random run lengths around the window
        void'($urandom(32'h5EED_0042));
        for (int it = 0; it < 40; it++) begin
            int  ch  = int'($urandom % 4);
            bit  lev = 1'($urandom);
            bit  flt = 1'($urandom);
            int  n   = window(flt);
            int  len = 1 + int'($urandom % (n + 3));
            logic [31:0] c = '0;
            c[ch*8 +: 8] = cbyte(1, lev, 0, flt);
            tamper_pin = '0;
            tamper_pin[ch] = ~lev;
            wr(2'd0, c);
            tick(3);
            wr(2'd2, 32'hF);
            tick(GAP);
            tamper_pin[ch] = lev;
            tick(len);
            tamper_pin[ch] = ~lev;
            tick(4);
            rd_chk($sformatf("R9 random ch%0d len %0d win %0d", ch, len, n), 2'd2,
                   (len >= n) ? (32'h1 << ch) : 32'h0);
            check("R10 random evt", {31'h0, tamper_evt}, {31'h0, len >= n});
        end

        summary();
    end
endmodule